// File: doc/BRIEF.md
# Endpoint Packet Buffer Address Generator

This block turns a packet-data access request for one USB endpoint into the byte address that a DMA engine should use in buffer memory. Software gives each endpoint an even start address. The block then works out which 64-byte region inside that endpoint's buffer area the access belongs to. The choice depends on which directions the endpoint has enabled, whether double buffering is on, the direction of the current transaction and the current data toggle. The block adds the byte offset within the packet to that region and returns the address one clock later, together with a valid flag.

The block supports two layouts. In the independent layout, an endpoint owns its whole buffer area. In the shared layout, the control endpoint and the auxiliary endpoint 4 use one start address: the control endpoint sits at the base, and the buffers of the auxiliary endpoint follow it. The block refuses an access to a disabled buffer or an offset past the end of a packet. It flags the offset case as an overflow, and in neither case does it issue a valid address.

Top module: `ep_buf_addr_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `valid_o`, `ovf_o` and `addr_o` are all zero.
- R2: A result appears exactly one clock after `req_i` is sampled high. A cycle with `req_i` low yields `valid_o=0` and `ovf_o=0` on the next cycle.
- R3: Bit 0 of `start_i` is ignored. The base is always the even address `{start_i[12:1],0}`.
- R4: In the independent layout (`shared_i=0`) with one direction enabled and `dbl_i=0`, the address is base + offset.
- R5: In the independent layout with one direction enabled and `dbl_i=1`, the address is base + 64·`tog_i` + offset.
- R6: In the independent layout with both directions enabled and `dbl_i=0`, receive (`dir_tx_i=0`) uses base + offset and transmit (`dir_tx_i=1`) uses base + 64 + offset.
- R7: In the independent layout with both directions enabled and `dbl_i=1`, receive uses base + 64·`tog_i` and transmit uses base + 128 + 64·`tog_i`, each plus the offset.
- R8: An access whose direction is not enabled gives `valid_o=0` and `ovf_o=0`. This covers an endpoint with both directions disabled, and the auxiliary endpoint in the shared layout.
- R9: In the shared layout (`shared_i=1`), the control endpoint (`ep4_sel_i=0`) always uses base + offset for both directions, whatever the values of the enables, `dbl_i` and `tog_i`.
- R10: In the shared layout with both auxiliary directions enabled, auxiliary receive uses base + 64 and auxiliary transmit uses base + 128, each plus the offset.
- R11: In the shared layout with only one auxiliary direction enabled, that direction uses base + 64 + offset.
- R12: An offset of 64 or more on an enabled buffer gives `ovf_o=1` and `valid_o=0`.
- R13: The address sum wraps modulo 2^13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request this cycle |
| shared_i | input | 1 | 1 selects the shared control/auxiliary layout |
| ep4_sel_i | input | 1 | In the shared layout, 1 addresses the auxiliary endpoint |
| rx_en_i | input | 1 | Receive buffer enabled (for the auxiliary endpoint in the shared layout) |
| tx_en_i | input | 1 | Transmit buffer enabled (for the auxiliary endpoint in the shared layout) |
| dbl_i | input | 1 | Double buffering, independent layout only |
| dir_tx_i | input | 1 | 0 receive, 1 transmit |
| tog_i | input | 1 | Current data toggle of the direction |
| start_i | input | 13 | Buffer area start address |
| offset_i | input | 7 | Byte offset within the packet |
| addr_o | output | 13 | Registered byte address |
| valid_o | output | 1 | Address is valid and may be issued |
| ovf_o | output | 1 | Offset is past the end of the packet buffer |

## Verification
The bench builds the block with its default parameters: a 13-bit address and 64-byte regions, so the offset port is 7 bits wide. Because the port is one bit wider than a packet index, offsets 63 and 64 can both be driven, and the overflow boundary is reached exactly. With a 13-bit space, a start address near 0x1FFE pushes region offsets and byte offsets across the top of the space, so the wrap can be observed. Each layout row is driven with a different start and offset, and one odd start checks that bit 0 is dropped.

// File: rtl/ep_addr_pkg.sv
package ep_addr_pkg;
    typedef enum logic [1:0] {
        SLOT_0 = 2'd0,
        SLOT_1 = 2'd1,
        SLOT_2 = 2'd2,
        SLOT_3 = 2'd3
    } slot_e;
endpackage

// File: rtl/ep_region_sel.sv
module ep_region_sel
    import ep_addr_pkg::*;
(
    input  logic  shared_i,
    input  logic  ep4_sel_i,
    input  logic  rx_en_i,
    input  logic  tx_en_i,
    input  logic  dbl_i,
    input  logic  dir_tx_i,
    input  logic  tog_i,
    output slot_e slot_o,
    output logic  hit_o
);
    logic dir_en;
    logic both_en;

    always_comb begin
        dir_en  = dir_tx_i ? tx_en_i : rx_en_i;
        both_en = rx_en_i && tx_en_i;
        hit_o   = dir_en;
        slot_o  = SLOT_0;
        if (shared_i) begin
            if (!ep4_sel_i) begin
                // control endpoint always lives at the base
                hit_o  = 1'b1;
                slot_o = SLOT_0;
            end else if (dir_tx_i && rx_en_i) begin
                slot_o = SLOT_2;
            end else begin
                slot_o = SLOT_1;
            end
        end else if (dbl_i) begin
            slot_o = slot_e'({both_en && dir_tx_i, tog_i});
        end else begin
            slot_o = slot_e'({1'b0, both_en && dir_tx_i});
        end
    end
endmodule

// File: rtl/ep_addr_add.sv
module ep_addr_add
    import ep_addr_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int BUF_BYTES = 64,
    localparam int IDX_W    = $clog2(BUF_BYTES),
    localparam int OFS_W    = IDX_W + 1
) (
    input  logic [ADDR_W-1:0] start_i,
    input  slot_e             slot_i,
    input  logic [OFS_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              past_end_o
);
    localparam logic [ADDR_W-1:0] REGION_A = ADDR_W'(BUF_BYTES);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] region;
    logic [ADDR_W-1:0] byte_ofs;

    always_comb begin
        base       = {start_i[ADDR_W-1:1], 1'b0};
        region     = ADDR_W'(slot_i) * REGION_A;
        byte_ofs   = ADDR_W'(offset_i[IDX_W-1:0]);
        addr_o     = base + region + byte_ofs;
        past_end_o = offset_i[IDX_W];
    end
endmodule

// File: rtl/ep_buf_addr_gen.sv
module ep_buf_addr_gen
    import ep_addr_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int BUF_BYTES = 64,
    localparam int OFS_W    = $clog2(BUF_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              shared_i,
    input  logic              ep4_sel_i,
    input  logic              rx_en_i,
    input  logic              tx_en_i,
    input  logic              dbl_i,
    input  logic              dir_tx_i,
    input  logic              tog_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [OFS_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              ovf_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              valid;
        logic              ovf;
    } out_t;

    out_t              st_d, st_q;
    slot_e             slot;
    logic              hit;
    logic [ADDR_W-1:0] sum_addr;
    logic              past_end;

    ep_region_sel u_sel (
        .shared_i  (shared_i),
        .ep4_sel_i (ep4_sel_i),
        .rx_en_i   (rx_en_i),
        .tx_en_i   (tx_en_i),
        .dbl_i     (dbl_i),
        .dir_tx_i  (dir_tx_i),
        .tog_i     (tog_i),
        .slot_o    (slot),
        .hit_o     (hit)
    );

    ep_addr_add #(
        .ADDR_W    (ADDR_W),
        .BUF_BYTES (BUF_BYTES)
    ) u_add (
        .start_i    (start_i),
        .slot_i     (slot),
        .offset_i   (offset_i),
        .addr_o     (sum_addr),
        .past_end_o (past_end)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.ovf   = 1'b0;
        if (req_i) begin
            st_d.addr  = sum_addr;
            st_d.ovf   = hit && past_end;
            st_d.valid = hit && !past_end;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr_o  = st_q.addr;
    assign valid_o = st_q.valid;
    assign ovf_o   = st_q.ovf;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> !valid_o); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!valid_o && !ovf_o)); // R2
    AST_DISABLED_EP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !shared_i && !rx_en_i && !tx_en_i) |=> (!valid_o && !ovf_o)); // R8
    AST_EVEN_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && offset_i[0] == 1'b0) |=> (addr_o[0] == 1'b0)); // R3
    AST_EP0_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && shared_i && !ep4_sel_i && offset_i == '0)
        |=> (valid_o && addr_o == {$past(start_i[ADDR_W-1:1]), 1'b0})); // R9
endmodule

// File: tb/sim_ep_buf_addr_gen.sv
module sim_ep_buf_addr_gen;
    localparam int AW = 13;
    localparam int OW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, shr = 1'b0, sel4 = 1'b0, rxe = 1'b0, txe = 1'b0;
    logic          dbl = 1'b0, dtx = 1'b0, tog = 1'b0;
    logic [AW-1:0] start = '0;
    logic [OW-1:0] ofs = '0;
    logic [AW-1:0] addr;
    logic          valid, ovf;
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    ep_buf_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .shared_i(shr), .ep4_sel_i(sel4),
        .rx_en_i(rxe), .tx_en_i(txe), .dbl_i(dbl), .dir_tx_i(dtx), .tog_i(tog),
        .start_i(start), .offset_i(ofs), .addr_o(addr), .valid_o(valid), .ovf_o(ovf)
    );

    // {shared, sel4, rx_en, tx_en, dbl, dir_tx, tog, slot[1:0], ok}
    localparam logic [9:0] VEC [0:21] = '{
        10'b0_0_10_0_0_1_00_1, // R4 rx only
        10'b0_0_01_0_1_0_00_1, // R4 tx only
        10'b0_0_10_1_0_1_01_1, // R5 rx dbl tog1
        10'b0_0_01_1_1_0_00_1, // R5 tx dbl tog0
        10'b0_0_01_1_1_1_01_1, // R5 tx dbl tog1
        10'b0_0_11_0_0_1_00_1, // R6 rx
        10'b0_0_11_0_1_0_01_1, // R6 tx
        10'b0_0_11_1_0_0_00_1, // R7 rx tog0
        10'b0_0_11_1_0_1_01_1, // R7 rx tog1
        10'b0_0_11_1_1_0_10_1, // R7 tx tog0
        10'b0_0_11_1_1_1_11_1, // R7 tx tog1
        10'b0_0_10_0_1_0_00_0, // R8 tx not enabled
        10'b0_0_00_1_0_0_00_0, // R8 none enabled
        10'b1_0_00_0_1_0_00_1, // R9 ep0 tx, no ep4 enables
        10'b1_0_11_1_0_1_00_1, // R9 ep0 rx, dbl and tog ignored
        10'b1_1_11_0_0_0_01_1, // R10 ep4 rx
        10'b1_1_11_0_1_1_10_1, // R10 ep4 tx
        10'b1_1_10_0_0_0_01_1, // R11 ep4 rx only
        10'b1_1_01_0_1_0_01_1, // R11 ep4 tx only
        10'b1_1_10_0_1_0_00_0, // R8 ep4 tx disabled
        10'b1_1_00_0_0_0_00_0, // R8 ep4 none
        10'b0_0_11_1_1_1_11_1  // R7 repeat, second pattern
    };

    task automatic check(input string tag, input logic [AW-1:0] ea,
                         input logic ev, input logic eo);
        checks++;
        if (valid !== ev || ovf !== eo || (ev && addr !== ea)) begin
            errors++;
            $display("FAIL %s: addr=%h valid=%b ovf=%b expected addr=%h valid=%b ovf=%b",
                     tag, addr, valid, ovf, ea, ev, eo);
        end
    endtask

    task automatic issue(input logic s, input logic e4, input logic r, input logic t,
                         input logic d, input logic dx, input logic tg,
                         input logic [AW-1:0] st, input logic [OW-1:0] of);
        @(negedge clk);
        req = 1'b1; shr = s; sel4 = e4; rxe = r; txe = t; dbl = d; dtx = dx; tog = tg;
        start = st; ofs = of;
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", '0, 1'b0, 1'b0);
        checks++;
        if (addr !== '0) begin errors++; $display("FAIL R1: addr=%h expected=0", addr); end
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", '0, 1'b0, 1'b0);

        for (int i = 0; i < 22; i++) begin
            logic [AW-1:0] st;
            logic [OW-1:0] of;
            logic [AW-1:0] ea;
            st = AW'(13'h0400 + i * 6);
            of = OW'((i * 3) % 64);
            ea = AW'(st + AW'(VEC[i][2:1]) * 13'd64 + AW'(of));
            issue(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5],
                  VEC[i][4], VEC[i][3], st, of);
            check($sformatf("table row %0d", i), ea, VEC[i][0], 1'b0);
        end

        // R2: idle cycle gives nothing; latency is exactly one clock
        @(negedge clk);
        check("R2 idle", '0, 1'b0, 1'b0);
        issue(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0100, 7'd5);
        check("R2 one-cycle result", 13'h0105, 1'b1, 1'b0);
        @(negedge clk);
        check("R2 drops after request", '0, 1'b0, 1'b0);

        // R3: odd start treated as even
        issue(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0235, 7'd0);
        check("R3 odd start", 13'h0234, 1'b1, 1'b0);

        // R12: offset boundary
        issue(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0200, 7'd63);
        check("R12 offset 63", 13'h023F, 1'b1, 1'b0);
        issue(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0200, 7'd64);
        check("R12 offset 64", '0, 1'b0, 1'b1);
        issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 13'h0200, 7'd127);
        check("R12 offset 127 ep0", '0, 1'b0, 1'b1);
        issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 13'h0200, 7'd100);
        check("R8 disabled hides overflow", '0, 1'b0, 1'b0);

        // R13: wrap of the 13-bit space
        issue(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 13'h1FFE, 7'd3);
        check("R13 wrap tx tog1", 13'h00C1, 1'b1, 1'b0);
        issue(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 13'h1FC0, 7'd1);
        check("R13 wrap ep4 tx", 13'h0041, 1'b1, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule